// File: doc/BRIEF.md
# GPIO Port Register Bank

The block is the register core of a byte-wide general-purpose I/O port. Four byte registers sit behind a two-bit register select: a read-only view of the pin levels, the output latch, a per-pin polarity mask and a per-pin direction mask. A pin set as an output drives the value held in the output latch. A pin set as an input leaves its driver released. The pin levels from the pads pass through a synchroniser, then through the polarity mask, and are then presented on the read-back data.

Change detection compares the polarity-adjusted level of every input pin against a snapshot. The snapshot is taken each time the host reads the input view, and the host signals that read with a strobe. A mismatch on any input pin pulls the active-low interrupt. The interrupt releases when the pin goes back to the level it had in the snapshot, or when a new strobe refreshes the snapshot. The serial bus front end that produces the strobes and the pad cells are outside the block.

Top module: `gpio_port_bank`

## Requirements
- R1: The register select decodes as follows: 0 is the input view (read-only), 1 is the output latch, 2 is the polarity mask and 3 is the direction mask. Reading 1, 2 or 3 returns the last value written to that register.
- R2: While `rst` is high, the output latch is held at 0xFF, the polarity mask at 0x00 and the direction mask at 0xFF. As a result, every `pin_oe` bit is 0 and `pin_drive` is 0xFF.
- R3: For each pin, `pin_oe` is the inverse of its direction bit, so a direction bit of 1 means input with the driver off. `pin_drive` always equals the output latch.
- R4: A write with select 0 changes no register and no output.
- R5: Reading select 0 returns, for every pin of either direction, the synchronised pin level XOR the polarity bit.
- R6: Reading select 1 returns the output latch and never the pin level.
- R7: `irq_n` is low exactly when some pin whose direction bit is 1 has an adjusted level that differs from the snapshot. Pins set as outputs never pull it.
- R8: A cycle with `in_rd_strobe` high loads the snapshot with the adjusted levels present in that cycle. This releases `irq_n` from the next cycle on, provided the pins hold still.
- R9: Without any read, `irq_n` releases once the offending pin is back at its snapshot level.
- R10: Rewriting a direction bit from 0 to 1 on a pin whose adjusted level differs from the snapshot pulls `irq_n` low in the cycle after the write.
- R11: A pin change reaches the select-0 read data and `irq_n` after exactly two rising clock edges.
- R12: During reset, the snapshot follows the synchronised pins. After a reset of at least three cycles, `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 2 | Register select for read-back |
| rd_data | output | 8 | Read-back byte |
| in_rd_strobe | input | 1 | Input view read; refreshes the snapshot |
| pin_in | input | 8 | Raw pad levels |
| pin_oe | output | 8 | Per-pin driver enable, 1 = drive |
| pin_drive | output | 8 | Per-pin drive value |
| irq_n | output | 1 | Change interrupt, active low |

## Verification
The bench builds the block with its defaults: an 8-bit port and a two-stage synchroniser. With these values a single flipped pin gives a known two-edge latency, and the four-entry select space can be covered completely. Mixed direction masks let the bench compare input pins and output pins side by side in one byte. It also checks the direction change that raises an unprompted interrupt. A random phase combines writes, strobes, pin toggles and resets in the same cycles. This exercises the corner where a strobe and a polarity write land in the same cycle.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    localparam int PORT_W      = 8;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_INV   = 2'd2,
        SEL_DIR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
    } wr_ctl_t;

    function automatic wr_ctl_t make_wr(input logic en, input logic [1:0] sel);
        wr_ctl_t c;
        c.en  = en;
        c.sel = reg_sel_e'(sel);
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) chain[s] <= chain[s-1];
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_ctl_t      wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] inv_q,
    output logic [W-1:0] dir_q
);
    localparam logic [W-1:0] ALL_ONE  = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= ALL_ONE;
            inv_q   <= ALL_ZERO;
            dir_q   <= ALL_ONE;
        end else if (wr.en) begin
            unique case (wr.sel)
                SEL_LATCH: latch_q <= wr_data;
                SEL_INV:   inv_q   <= wr_data;
                SEL_DIR:   dir_q   <= wr_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_change_det.sv
`timescale 1ns/1ps
module gpio_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] inv,
    input  logic [W-1:0] dir,
    input  logic         snap_en,
    output logic [W-1:0] adj,
    output logic [W-1:0] snap_q,
    output logic         irq_n
);
    logic [W-1:0] diff;

    assign adj = level ^ inv;

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= level;
        else if (snap_en) snap_q <= adj;
    end

    assign diff  = (adj ^ snap_q) & dir;
    assign irq_n = ~(|diff);
endmodule

// File: rtl/gpio_port_bank.sv
`timescale 1ns/1ps
module gpio_port_bank
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W,
    parameter int SYNC  = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [WIDTH-1:0] rd_data,
    input  logic             in_rd_strobe,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_drive,
    output logic             irq_n
);
    logic [WIDTH-1:0] lvl_s;
    logic [WIDTH-1:0] latch_q, inv_q, dir_q;
    logic [WIDTH-1:0] in_adj, cap_q;
    wr_ctl_t          wctl;

    assign wctl = make_wr(wr_en, wr_sel);

    gpio_sync #(.W(WIDTH), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (lvl_s)
    );

    gpio_regs #(.W(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wctl),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .inv_q   (inv_q),
        .dir_q   (dir_q)
    );

    gpio_change_det #(.W(WIDTH)) u_det (
        .clk     (clk),
        .rst     (rst),
        .level   (lvl_s),
        .inv     (inv_q),
        .dir     (dir_q),
        .snap_en (in_rd_strobe),
        .adj     (in_adj),
        .snap_q  (cap_q),
        .irq_n   (irq_n)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_LEVEL: rd_data = in_adj;
            SEL_LATCH: rd_data = latch_q;
            SEL_INV:   rd_data = inv_q;
            SEL_DIR:   rd_data = dir_q;
            default:   rd_data = '0;
        endcase
    end

    assign pin_oe    = ~dir_q;
    assign pin_drive = latch_q;
endmodule

// File: rtl/gpio_port_bank_chk.sv
`timescale 1ns/1ps
module gpio_port_bank_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [WIDTH-1:0] wr_data,
    input logic             in_rd_strobe,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_drive,
    input logic             irq_n,
    input logic [WIDTH-1:0] adj,
    input logic [WIDTH-1:0] snap
);
    p_defaults_r2: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && pin_drive == '1));

    p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> (pin_oe == ~$past(wr_data)));

    p_sel0_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> ($stable(pin_oe) && $stable(pin_drive)));

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 2'd1) |=> $stable(pin_drive));

    p_outputs_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (pin_oe == '1) |-> irq_n);

    p_snap_load_r8: assert property (@(posedge clk) disable iff (rst)
        in_rd_strobe |=> (snap == $past(adj)));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .in_rd_strobe (in_rd_strobe),
    .pin_oe       (pin_oe),
    .pin_drive    (pin_drive),
    .irq_n        (irq_n),
    .adj          (in_adj),
    .snap         (cap_q)
);

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;
    localparam int W = 8;
    localparam int MAX_CYC = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data;
    logic         in_rd_strobe = 1'b0;
    logic [W-1:0] pin_in = 8'hA5;
    logic [W-1:0] pin_oe, pin_drive;
    logic         irq_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference
    logic [W-1:0] m_s1 = '0, m_s2 = '0;
    logic [W-1:0] m_out, m_pol, m_cfg, m_snap;

    always #4 clk = ~clk;

    gpio_port_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .in_rd_strobe(in_rd_strobe),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_drive(pin_drive), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [W-1:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return m_s2 ^ m_pol;
            2'd1: return m_out;
            2'd2: return m_pol;
            default: return m_cfg;
        endcase
    endfunction

    function automatic logic m_irq_n();
        return ~(|(((m_s2 ^ m_pol) ^ m_snap) & m_cfg));
    endfunction

    task automatic compare_all();
        string t;
        if (cyc < 4) return;
        if (rst) t = "R2";
        else case (rd_sel)
            2'd0: t = "R5";
            2'd1: t = "R6";
            default: t = "R1";
        endcase
        chk(t, rd_data, m_read(rd_sel));
        chk(rst ? "R2" : "R3", pin_oe, ~m_cfg);
        chk(rst ? "R2" : "R3", pin_drive, m_out);
        chk(rst ? "R12" : "R7", {7'd0, irq_n}, {7'd0, m_irq_n()});
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_out = '1; m_pol = '0; m_cfg = '1; m_snap = m_s2;
        end else begin
            if (in_rd_strobe) m_snap = m_s2 ^ m_pol;
            if (wr_en) case (wr_sel)
                2'd1: m_out = wr_data;
                2'd2: m_pol = wr_data;
                2'd3: m_cfg = wr_data;
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = pin_in;
        cyc++;
        @(negedge clk);
        compare_all();
    endtask

    task automatic peek(input logic [1:0] s, input logic [W-1:0] exp, input string tag);
        rd_sel = s;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_out = '1; m_pol = '0; m_cfg = '1; m_snap = '0;
        @(negedge clk);
        repeat (5) tick();
        // R2 / R12: defaults held during reset
        peek(2'd1, 8'hFF, "R2");
        peek(2'd2, 8'h00, "R2");
        peek(2'd3, 8'hFF, "R2");
        chk("R2", pin_oe, 8'h00);
        chk("R12", {7'd0, irq_n}, 8'h01);
        rst = 1'b0;
        tick();
        chk("R12", {7'd0, irq_n}, 8'h01);

        // R1 / R5: polarity write and adjusted input view
        wr(2'd2, 8'h0F);
        peek(2'd2, 8'h0F, "R1");
        peek(2'd0, 8'hAA, "R5");
        chk("R7", {7'd0, irq_n}, 8'h00);
        in_rd_strobe = 1'b1; tick(); in_rd_strobe = 1'b0;
        chk("R8", {7'd0, irq_n}, 8'h01);

        // R3 / R6: mixed directions
        wr(2'd3, 8'hF0);
        wr(2'd1, 8'h3C);
        peek(2'd1, 8'h3C, "R6");
        chk("R3", pin_oe, 8'h0F);
        chk("R3", pin_drive, 8'h3C);

        // R4: select 0 write ignored
        wr(2'd0, 8'h55);
        peek(2'd1, 8'h3C, "R4");
        peek(2'd2, 8'h0F, "R4");
        peek(2'd3, 8'hF0, "R4");
        chk("R4", pin_oe, 8'h0F);
        chk("R4", pin_drive, 8'h3C);

        // R11: two-edge latency of an input pin change
        pin_in = 8'hB5;
        tick();
        chk("R11", {7'd0, irq_n}, 8'h01);
        peek(2'd0, 8'hAA, "R11");
        tick();
        chk("R11", {7'd0, irq_n}, 8'h00);
        peek(2'd0, 8'hBA, "R11");

        // R9: return to snapshot level releases
        pin_in = 8'hA5;
        tick(); tick();
        chk("R9", {7'd0, irq_n}, 8'h01);

        // R7: output pin change visible but silent
        pin_in = 8'hA4;
        tick(); tick(); tick();
        chk("R7", {7'd0, irq_n}, 8'h01);
        peek(2'd0, 8'hAB, "R5");

        // R10: turning an output into an input with mismatch
        wr(2'd3, 8'hFF);
        chk("R10", {7'd0, irq_n}, 8'h00);

        // R2: mid-run reset
        rst = 1'b1;
        tick(); tick(); tick();
        peek(2'd1, 8'hFF, "R2");
        peek(2'd3, 8'hFF, "R2");
        chk("R12", {7'd0, irq_n}, 8'h01);
        rst = 1'b0;

        // random phase, model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            rst          = ($urandom_range(0, 99) == 0);
            wr_en        = ($urandom_range(0, 2) == 0);
            wr_sel       = 2'($urandom_range(0, 3));
            wr_data      = 8'($urandom);
            in_rd_strobe = ($urandom_range(0, 3) == 0);
            rd_sel       = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ (8'd1 << $urandom_range(0, 7));
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule